// File: doc/BRIEF.md
# Interrupt Event Flag and Alarm Comparator

This block collects the three interrupt sources of a real-time clock into flags that the host can read. A periodic pulse from the rate divider and an update-done pulse from the timekeeping counters arrive as inputs. The current seconds, minutes and hours also arrive as inputs. On every update-done cycle, those three time values are compared against three host-written alarm bytes.

Each event sets its own flag, whether or not its interrupt is enabled. A summary bit and a level interrupt output show whether any flag is pending whose enable bit is set. The host reads the flags through a status register that cannot be written. That read clears every event flag. An event that lands in the same cycle as the read is kept, so it is not lost.

The host bus is a simple one. Register writes take effect at the clock edge. Read data is combinational from the address.

Register offsets:

| Offset | Register |
|--------|----------|
| 0 | alarm seconds |
| 1 | alarm minutes |
| 2 | alarm hours |
| 3 | enable register |
| 4 | status register |

Top module: `irq_event_ctrl`

## Requirements
- R1: A `tick_periodic` pulse sets the periodic flag, status bit 6, at the next clock edge, whatever the enable bits hold.
- R2: An `upd_done` pulse sets the update-ended flag, status bit 4, at the next clock edge, whatever the enable bits hold.
- R3: On an `upd_done` cycle, the alarm flag (status bit 5) sets when all three of these pairs are equal: seconds and alarm byte 0, minutes and alarm byte 1, hours and alarm byte 2. A mismatch in any one of them leaves the alarm flag clear.
- R4: An alarm byte whose two top bits are both 1 (0xC0 to 0xFF) matches any current value.
- R5: The enable register (offset 3) holds the enables at these bits: periodic at bit 6, alarm at bit 5, update-ended at bit 4. Its other bits read as 0. Status bit 7 is 1 exactly while at least one flag is set whose enable bit is also set.
- R6: `irq` is high exactly while status bit 7 is 1.
- R7: A read of the status register returns the current flags. At that clock edge it clears bits 6 to 4, and with them bit 7 and `irq`.
- R8: An event pulse that arrives in the same cycle as a status read leaves its flag set after the read.
- R9: Host writes to the status register change nothing. Status bits 3 to 0 always read as 0.
- R10: After reset, the alarm bytes, the enables and all flags are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cur_sec | input | 8 | current seconds |
| cur_min | input | 8 | current minutes |
| cur_hour | input | 8 | current hours |
| tick_periodic | input | 1 | periodic-rate pulse, one cycle |
| upd_done | input | 1 | update-ended pulse, one cycle |
| wr_en | input | 1 | host write strobe |
| rd_en | input | 1 | host read strobe |
| addr | input | 3 | register offset |
| wr_data | input | 8 | host write data |
| rd_data | output | 8 | host read data, combinational from `addr` |
| irq | output | 1 | level interrupt, active high |

## Verification
A pulse or a write that is presented before a clock edge shows up in `rd_data` and `irq` straight after that edge. There is one register stage on the way: the flag register or the enable register. The read value is combinational, so it is sampled 1 ns after the falling edge on which the read strobe is driven. The clearing from that read is visible after the following rising edge. All stimulus is driven on falling edges. Every check is taken at the next falling edge or later, so a sample never races the rising edge that updates the block.

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic          tick_periodic,
  input  logic          upd_done,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_ASEC = AW'(0);
  localparam logic [AW-1:0] OFS_AMIN = AW'(1);
  localparam logic [AW-1:0] OFS_AHR  = AW'(2);
  localparam logic [AW-1:0] OFS_ENA  = AW'(3);
  localparam logic [AW-1:0] OFS_STAT = AW'(4);
  localparam int LOW_W = DW - 4;

  logic [DW-1:0] alm_sec, alm_min, alm_hr;
  logic [2:0]    ena;
  logic [2:0]    flg;
  logic          hit, stat_rd, summ;
  logic [2:0]    ev;

  function automatic logic fld_match(input logic [DW-1:0] alm, input logic [DW-1:0] cur);
    return (alm[DW-1:DW-2] == 2'b11) || (alm == cur);
  endfunction

  assign hit     = upd_done && fld_match(alm_sec, cur_sec) &&
                   fld_match(alm_min, cur_min) && fld_match(alm_hr, cur_hour);
  assign ev      = {tick_periodic, hit, upd_done};
  assign stat_rd = rd_en && (addr == OFS_STAT);
  assign summ    = |(flg & ena);
  assign irq     = summ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_sec <= '0;
      alm_min <= '0;
      alm_hr  <= '0;
      ena     <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_ASEC: alm_sec <= wr_data;
        OFS_AMIN: alm_min <= wr_data;
        OFS_AHR:  alm_hr  <= wr_data;
        OFS_ENA:  ena     <= wr_data[DW-2:DW-4];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flg <= '0;
    else        flg <= (stat_rd ? 3'b000 : flg) | ev;
  end

  always_comb begin
    case (addr)
      OFS_ASEC: rd_data = alm_sec;
      OFS_AMIN: rd_data = alm_min;
      OFS_AHR:  rd_data = alm_hr;
      OFS_ENA:  rd_data = {1'b0, ena, {LOW_W{1'b0}}};
      OFS_STAT: rd_data = {summ, flg, {LOW_W{1'b0}}};
      default:  rd_data = '0;
    endcase
  end

  assert_pf_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_periodic |=> flg[2]);
  assert_uf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> flg[0]);
  assert_af_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[1]) |-> $past(upd_done));
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tick_periodic && !upd_done) |=> (flg == 3'b000 && !irq));
  assert_stat_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_STAT && !rd_en && !tick_periodic && !upd_done) |=> $stable(flg));
  assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flg != 3'b000));
endmodule

// File: tb/test_irq_event_ctrl.sv
module test_irq_event_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, wr_data = '0, rd_data;
  logic       tick_periodic = 1'b0, upd_done = 1'b0, wr_en = 1'b0, rd_en = 1'b0, irq;
  logic [2:0] addr = '0;
  int checks = 0, errors = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  irq_event_ctrl i_irq_event_ctrl (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic tk, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; tick_periodic = tk; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0; tick_periodic = 1'b0;
  endtask

  task automatic pulse(input logic tk, input logic up);
    @(negedge clk); tick_periodic = tk; upd_done = up;
    @(negedge clk); tick_periodic = 1'b0; upd_done = 1'b0;
  endtask

  task automatic t_reset;
    rd(3'd0, 0, got); chk("R10 alarm sec", got, 8'h00);
    rd(3'd3, 0, got); chk("R10 enables", got, 8'h00);
    rd(3'd4, 0, got); chk("R10 status", got, 8'h00);
    chk("R10 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_update_alarm;
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h05);
    cur_sec = 8'h12; cur_min = 8'h34; cur_hour = 8'h05;
    pulse(0, 1);
    chk("R3 irq disabled", {7'b0, irq}, 8'h00);
    rd(3'd4, 0, got); chk("R3 R2 match", got, 8'h30);
    rd(3'd4, 0, got); chk("R7 cleared", got, 8'h00);
    cur_sec = 8'h13; pulse(0, 1);
    rd(3'd4, 0, got); chk("R3 mismatch", got, 8'h10);
    cur_sec = 8'h12; pulse(1, 0);
    rd(3'd4, 0, got); chk("R3 no update", got, 8'h40);
  endtask

  task automatic t_dont_care;
    wr(3'd0, 8'hC0); wr(3'd2, 8'hFF);
    cur_sec = 8'h59; cur_hour = 8'h11; pulse(0, 1);
    rd(3'd4, 0, got); chk("R4 wildcard", got, 8'h30);
    wr(3'd0, 8'h80); pulse(0, 1);
    rd(3'd4, 0, got); chk("R4 bit7 only", got, 8'h10);
  endtask

  task automatic t_enable_irq;
    wr(3'd3, 8'h4F);
    rd(3'd3, 0, got); chk("R5 enable readback", got, 8'h40);
    pulse(1, 0);
    chk("R6 irq high", {7'b0, irq}, 8'h01);
    wr(3'd3, 8'h20);
    chk("R5 other enable", {7'b0, irq}, 8'h00);
    wr(3'd3, 8'h40);
    rd(3'd4, 0, got); chk("R5 summary", got, 8'hC0);
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_coincide;
    pulse(1, 0);
    rd(3'd4, 1, got); chk("R8 read value", got, 8'hC0);
    chk("R8 irq kept", {7'b0, irq}, 8'h01);
    rd(3'd4, 0, got); chk("R8 flag kept", got, 8'hC0);
    rd(3'd4, 0, got); chk("R8 then clear", got, 8'h00);
  endtask

  task automatic t_status_ro;
    wr(3'd4, 8'hFF);
    chk("R9 irq", {7'b0, irq}, 8'h00);
    rd(3'd4, 0, got); chk("R9 write ignored", got, 8'h00);
    wr(3'd3, 8'h10); pulse(0, 1);
    rd(3'd4, 0, got); chk("R9 low bits", got & 8'h0F, 8'h00);
    chk("R2 update enabled", got, 8'h90);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset; t_update_alarm; t_dont_care; t_enable_irq; t_coincide; t_status_ro;
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule